// File: doc/BRIEF.md
# Row-Scanned Keypad Encoder with Debounce

This block reads a 12-key switch matrix of four rows and three columns. It pulls one row low at a time and leaves the other rows high. Each column input goes through a two-flop synchronizer. After the row drive changes, the block waits a fixed number of settle cycles and then looks at the columns. A column that reads low marks a closed switch where it crosses the driven row. If no column is low in any row, no key is pressed.

When a closure is found, the block stops scanning and keeps driving that row. The column it found must then stay low for a debounce interval, counted in clock ticks, before the key counts as confirmed. A confirmed key gives a one-cycle report that carries a key number computed from the 1-based row and column. The held key is reported once only. The block reports nothing more until every column in that row has read high for a full debounce interval, and only then does scanning resume. The debounce length is a parameter. A real design sets it to tens or hundreds of milliseconds of clock ticks. A simulation uses a few dozen ticks.

Top module: `keypad_scan`

## Requirements
- R1: While reset is active, and in the first cycle after it, row 0 is driven: row_n = 4'b1110 and key_valid is low. At every moment exactly one row output is low and the others are high.
- R2: When no key is closed, each row stays driven for exactly SETTLE_CYCLES clock cycles. The rows are driven in the order 0, 1, 2, 3, and the scan then wraps back to row 0.
- R3: key_code equals col + 3*row - 3, where row and col count from 1 (row r maps to row_n bit r-1 and col c maps to col_n bit c-1). The codes are therefore 1 to 12, as a 4-bit unsigned value.
- R4: If several columns read low while the same row is driven, the key in the lowest-numbered column is taken.
- R5: A key is reported only if its column stays low for DEBOUNCE_CYCLES consecutive cycles after it is detected. If the column goes high earlier, the candidate is dropped, no report is made, and scanning resumes.
- R6: Each confirmed press produces exactly one key_valid pulse, one cycle wide, however long the key is held.
- R7: After a report, no new key is accepted until all columns of the held row have read high for DEBOUNCE_CYCLES consecutive cycles. A shorter release followed by a new press of the same key gives no second report. Keys in other rows are ignored until this break is confirmed.
- R8: With no key closed, key_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_n | input | COLS (3) | Column sense lines, asynchronous, low when a switch on the driven row is closed |
| row_n | output | ROWS (4) | Row drive lines, one low at a time |
| key_valid | output | 1 | One-cycle pulse for a confirmed key |
| key_code | output | 4 | Key number 1 to 12, valid while key_valid is high |

## Verification
Two functions can act in the same stretch of time: the confirmation that the held key has been released, and the detection of a new closure. The bench provokes this by holding a key in row 0 and pressing a key in row 2 while the first is still down. It then releases the first key and keeps the second closed. The scoreboard must see exactly one report for each key, in order. It must see no report of the second key before the release of the first has run its full debounce. A short release followed by a new press of the same key must give no report at all.

// File: rtl/keypad_scan.sv
module keypad_scan #(
  parameter int ROWS            = 4,
  parameter int COLS            = 3,
  parameter int CODE_W          = 4,
  parameter int SETTLE_CYCLES   = 3,
  parameter int DEBOUNCE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_n,
  output logic [ROWS-1:0]   row_n,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);

  typedef enum logic [1:0] {S_SCAN, S_DEB, S_HELD} state_t;

  state_t            state;
  logic [COLS-1:0]   col_m, col_s;
  logic [RW-1:0]     row_q;
  logic [CW-1:0]     cand_c, hit_c;
  logic [SW-1:0]     st_cnt;
  logic [DW-1:0]     db_cnt;
  logic              any_low, settled, db_done;

  assign row_n   = ~(ROWS'(1) << row_q);
  assign any_low = ~&col_s;
  assign settled = (st_cnt == SW'(SETTLE_CYCLES - 1));
  assign db_done = (db_cnt == DW'(DEBOUNCE_CYCLES - 1));

  always_comb begin
    hit_c = '0;
    for (int i = COLS - 1; i >= 0; i--)
      if (!col_s[i]) hit_c = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_m <= '1;
      col_s <= '1;
    end else begin
      col_m <= col_n;
      col_s <= col_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_SCAN;
      row_q     <= '0;
      cand_c    <= '0;
      st_cnt    <= '0;
      db_cnt    <= '0;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      key_valid <= 1'b0;
      case (state)
        S_SCAN: begin
          if (settled) begin
            st_cnt <= '0;
            if (any_low) begin
              cand_c <= hit_c;
              db_cnt <= '0;
              state  <= S_DEB;
            end else begin
              row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
            end
          end else begin
            st_cnt <= st_cnt + 1'b1;
          end
        end
        S_DEB: begin
          if (col_s[cand_c]) begin
            st_cnt <= '0;
            state  <= S_SCAN;
          end else if (db_done) begin
            key_valid <= 1'b1;
            key_code  <= CODE_W'((int'(cand_c) + 1) + COLS * (int'(row_q) + 1) - COLS);
            db_cnt    <= '0;
            state     <= S_HELD;
          end else begin
            db_cnt <= db_cnt + 1'b1;
          end
        end
        S_HELD: begin
          if (any_low) begin
            db_cnt <= '0;
          end else if (db_done) begin
            db_cnt <= '0;
            st_cnt <= '0;
            state  <= S_SCAN;
          end else begin
            db_cnt <= db_cnt + 1'b1;
          end
        end
        default: state <= S_SCAN;
      endcase
    end
  end

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_code >= CODE_W'(1) && key_code <= CODE_W'(ROWS * COLS))); // R3

  AST_REPORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !$past(col_s[cand_c])); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R6

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_SCAN) |=> $stable(row_n)); // R7

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_n) == ROWS - 1); // R1
endmodule

// File: tb/keypad_scan_tb.sv
module keypad_scan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int SETTLE = 3;
  localparam int DEB = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic            key_valid;
  logic [3:0]      key_code;
  logic [COLS-1:0] keys [ROWS];

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scan #(.ROWS(ROWS), .COLS(COLS), .CODE_W(4),
                .SETTLE_CYCLES(SETTLE), .DEBOUNCE_CYCLES(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .col_n(col_n),
    .row_n(row_n), .key_valid(key_valid), .key_code(key_code));

  always_comb begin
    col_n = '1;
    for (int r = 0; r < ROWS; r++)
      if (!row_n[r]) col_n = col_n & ~keys[r];
  end

  function automatic int code_of(int r, int c);
    return (c + 1) + 3 * (r + 1) - 3;
  endfunction

  task automatic set_key(int r, int c, bit v);
    @(negedge clk);
    keys[r][c] = v;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_key(int r, int c);
    exp_q.push_back(code_of(r, c));
  endtask

  always @(negedge clk) begin
    if (rst_n && key_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected report got %0d expected none", key_code);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(key_code) != e) begin
          errors++;
          $display("FAIL R3 key code got %0d expected %0d", key_code, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [ROWS-1:0] prev;
    int idx, held;
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (row_n !== 4'b1110) begin
      errors++;
      $display("FAIL R1 reset row got %b expected 1110", row_n);
    end
    checks++;
    if (key_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset key_valid got %b expected 0", key_valid);
    end

    // R2: scan order and dwell per row with no key closed
    prev = row_n;
    idx = 0;
    held = 1;
    while (idx < 5) begin
      @(negedge clk);
      if (row_n == prev) held++;
      else begin
        checks++;
        if ((idx > 0 && held != SETTLE) || row_n !== ~(4'b1 << ((idx + 1) % ROWS))) begin
          errors++;
          $display("FAIL R2 row step got %b held %0d expected %b held %0d",
                   row_n, held, ~(4'b1 << ((idx + 1) % ROWS)), SETTLE);
        end
        idx++;
        held = 1;
        prev = row_n;
      end
    end

    // R8: idle, nothing reported
    wait_cyc(200);

    // R3 R6: a clean long press is reported once
    expect_key(1, 2);
    set_key(1, 2, 1);
    wait_cyc(4 * DEB);
    set_key(1, 2, 0);
    wait_cyc(3 * DEB);

    // R5: closure shorter than the debounce window is dropped
    set_key(2, 0, 1);
    wait_cyc(DEB / 2);
    set_key(2, 0, 0);
    wait_cyc(3 * DEB);

    // R5: bouncing contact, then stable: one report
    for (int k = 0; k < 4; k++) begin
      set_key(0, 1, 1);
      wait_cyc(10);
      set_key(0, 1, 0);
      wait_cyc(6);
    end
    expect_key(0, 1);
    set_key(0, 1, 1);
    wait_cyc(4 * DEB);
    set_key(0, 1, 0);
    wait_cyc(3 * DEB);

    // R4: two keys on one row, lower column wins (code 10)
    expect_key(3, 0);
    keys[3][2] = 1'b1;
    set_key(3, 0, 1);
    wait_cyc(4 * DEB);
    keys[3][2] = 1'b0;
    set_key(3, 0, 0);
    wait_cyc(3 * DEB);

    // R7: other-row key pressed while one is held; reported only after the break
    expect_key(0, 0);
    set_key(0, 0, 1);
    wait_cyc(3 * DEB);
    set_key(2, 1, 1);
    wait_cyc(2 * DEB);
    expect_key(2, 1);
    set_key(0, 0, 0);
    wait_cyc(4 * DEB);
    set_key(2, 1, 0);
    wait_cyc(3 * DEB);

    // R7: short release of the same key gives no second report
    expect_key(1, 1);
    set_key(1, 1, 1);
    wait_cyc(3 * DEB);
    set_key(1, 1, 0);
    wait_cyc(10);
    set_key(1, 1, 1);
    wait_cyc(4 * DEB);
    set_key(1, 1, 0);
    wait_cyc(3 * DEB);
    expect_key(1, 1);
    set_key(1, 1, 1);
    wait_cyc(3 * DEB);
    set_key(1, 1, 0);
    wait_cyc(3 * DEB);

    // R3: highest code, key 12
    expect_key(3, 2);
    set_key(3, 2, 1);
    wait_cyc(3 * DEB);
    set_key(3, 2, 0);
    wait_cyc(3 * DEB);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 missing reports got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule